// File: doc/BRIEF.md
# Multi-Mode Pixel Word Unpacker

This block sits behind a 16-bit pixel input bus. On every rising clock edge it samples the pixel word, an active-high display-enable input (`blank_n`, low during blanking) and a primary/secondary format selector. It rebuilds a complete pixel from one, two or three bus words. The result is either a 24-bit RGB colour that goes straight past the palette, or an 8-bit palette index. A one-cycle strobe marks each finished pixel, and a delayed copy of the display enable comes out beside it.

The active format is chosen in one of two ways. With extended formats disabled, a 3-bit legacy code picks it. With extended formats enabled, one of two 8-bit mode codes picks it, primary or secondary as the selector input says. Multi-word formats send the low-order byte first. Colour fields may be split across words. Word alignment restarts at every rising edge of the display enable.

Top module: `pixel_word_unpacker`

## Requirements
- R1: With `ext_en`=0 the `legacy_cmd` codes are decoded as follows, with unsupplied colour bits set to 0:
  - 000: an index taken from P7..P0.
  - 101: two bytes on P7..P0. The first byte is G5..G3 (bits 7..5) and B7..B3 (bits 4..0). The second byte is an ignored bit 7, R7..R3 (bits 6..2) and G7..G6 (bits 1..0).
  - 110: two bytes. The first byte is G4..G2 (7..5) and B7..B3 (4..0). The second byte is R7..R3 (7..3) and G7..G5 (2..0).
  - 111: three bytes in the order blue, green, red.
- R2: The legacy codes 001, 010, 011 and 100 never produce a pixel strobe.
- R3: Extended code 03h takes one word with R7..R3 in bits 15..11, G7..G2 in bits 10..5 and B7..B3 in bits 4..0. Code 02h takes R in bits 14..10, G in 9..5 and B in 4..0, and ignores bit 15.
- R4: Extended code 04h takes two words. The first has green in bits 15..8 and blue in 7..0. The second has red in bits 7..0.
- R5: Extended code 07h builds an index from two nibbles on P3..P0. The first nibble gives index bits 3..0 and the second gives bits 7..4.
- R6: Extended code 00h gives an index from P7..P0. Code 01h gives an index from P7..P0 when P15=0, and a 02h-layout colour from P14..P0 when P15=1.
- R7: Extended codes 05h and 09h, and every code above 09h, never produce a pixel strobe.
- R8: With `ext_en`=1, `mode_sel`=0 selects `prim_mode` and `mode_sel`=1 selects `sec_mode`. With `ext_en`=0, `mode_sel` has no effect.
- R9: `mode_sel` is sampled only on the first word of a pixel. A change on a later word of the same pixel does not alter that pixel.
- R10: While `blank_n` is low the word position stays at the first word and no pixel strobe is produced. A partly received pixel is discarded, and the next rising edge of `blank_n` starts a new pixel.
- R11: `px_valid` is high for exactly one cycle, right after the edge that captures the final word of a pixel. `px_direct` is 1 for colour results and 0 for index results. `px_blank_n` equals `blank_n` delayed by one clock.
- R12: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_word | input | 16 | Pixel bus word |
| blank_n | input | 1 | Display enable, low during blanking |
| mode_sel | input | 1 | 0 selects the primary code, 1 the secondary code |
| ext_en | input | 1 | Enables the extended format codes |
| legacy_cmd | input | 3 | Legacy format code |
| prim_mode | input | 8 | Primary extended format code |
| sec_mode | input | 8 | Secondary extended format code |
| px_valid | output | 1 | One-cycle strobe for a finished pixel |
| px_direct | output | 1 | 1 when the result is RGB, 0 when it is an index |
| px_rgb | output | 24 | Colour result, red in 23..16, green in 15..8, blue in 7..0 |
| px_index | output | 8 | Palette index result |
| px_blank_n | output | 1 | Display enable delayed by one clock |

## Verification
Two events can land on the same edge: the capture of a later word of a multi-word pixel, and a change of `mode_sel` toward a format of different length. The bench flips `mode_sel` exactly on the second word of a two-word extended pixel. It then judges that the assembled colour still follows the first word's primary layout and that the strobe lands on the second edge. A second collision, a display-enable drop in mid-pixel followed by a fresh rising edge, is judged by whether the next three bytes form a clean pixel with no strobe in between.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
   typedef enum logic [3:0] {
      FMT_NONE,
      FMT_IDX8,   // index on P7..P0
      FMT_B555,   // two bytes, 5-5-5
      FMT_B565,   // two bytes, 5-6-5
      FMT_B888,   // three bytes, blue/green/red
      FMT_W555,   // one word, 5-5-5
      FMT_W565,   // one word, 5-6-5
      FMT_W888,   // two words, green:blue then red
      FMT_NIB,    // two nibbles form an index
      FMT_MIX     // P15 chooses index or 5-5-5
   } pxu_fmt_e;

   function automatic logic [1:0] fmt_words(pxu_fmt_e f);
      case (f)
         FMT_B555, FMT_B565, FMT_W888, FMT_NIB: fmt_words = 2'd2;
         FMT_B888:                              fmt_words = 2'd3;
         default:                               fmt_words = 2'd1;
      endcase
   endfunction
endpackage

// File: rtl/pxu_fmt_decode.sv
module pxu_fmt_decode
   import pxu_pkg::*;
#(
   parameter int CMD_W  = 3,
   parameter int MODE_W = 8
) (
   input  logic              ext_en,
   input  logic [CMD_W-1:0]  legacy_cmd,
   input  logic [MODE_W-1:0] prim_mode,
   input  logic [MODE_W-1:0] sec_mode,
   input  logic              mode_sel,
   output pxu_fmt_e          fmt
);
   logic [MODE_W-1:0] ext_code;
   pxu_fmt_e          fmt_leg;
   pxu_fmt_e          fmt_ext;

   assign ext_code = mode_sel ? sec_mode : prim_mode;

   always_comb begin
      case (legacy_cmd)
         3'b000:  fmt_leg = FMT_IDX8;
         3'b101:  fmt_leg = FMT_B555;
         3'b110:  fmt_leg = FMT_B565;
         3'b111:  fmt_leg = FMT_B888;
         default: fmt_leg = FMT_NONE;
      endcase
   end

   always_comb begin
      case (ext_code)
         8'h00:   fmt_ext = FMT_IDX8;
         8'h01:   fmt_ext = FMT_MIX;
         8'h02:   fmt_ext = FMT_W555;
         8'h03:   fmt_ext = FMT_W565;
         8'h04:   fmt_ext = FMT_W888;
         8'h06:   fmt_ext = FMT_B565;
         8'h07:   fmt_ext = FMT_NIB;
         8'h08:   fmt_ext = FMT_B555;
         default: fmt_ext = FMT_NONE;
      endcase
   end

   assign fmt = ext_en ? fmt_ext : fmt_leg;
endmodule

// File: rtl/pxu_word_seq.sv
module pxu_word_seq
   import pxu_pkg::*;
#(
   parameter int MAX_WORDS = 3,
   localparam int CNT_W    = $clog2(MAX_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blank_n,
   input  pxu_fmt_e         fmt_now,
   output pxu_fmt_e         fmt_use,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;
   pxu_fmt_e         fmt_q;
   logic [1:0]       n_words;

   assign fmt_use = (cnt_q == '0) ? fmt_now : fmt_q;
   assign n_words = fmt_words(fmt_use);
   assign last    = blank_n && (fmt_use != FMT_NONE) &&
                    (cnt_q == CNT_W'(n_words - 2'd1));
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         fmt_q <= FMT_NONE;
      end else begin
         if (!blank_n || fmt_use == FMT_NONE || last)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
         if (blank_n && cnt_q == '0)
            fmt_q <= fmt_now;
      end
   end
endmodule

// File: rtl/pxu_assemble.sv
module pxu_assemble
   import pxu_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int CH_W      = 8,
   parameter int MAX_WORDS = 3,
   localparam int CNT_W    = $clog2(MAX_WORDS),
   localparam int HOLD_N   = MAX_WORDS - 1,
   localparam int RGB_W    = 3 * CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blank_n,
   input  logic [WORD_W-1:0] word,
   input  logic [CNT_W-1:0]  cnt,
   input  pxu_fmt_e          fmt_use,
   input  logic              last,
   output logic              px_valid,
   output logic              px_direct,
   output logic [RGB_W-1:0]  px_rgb,
   output logic [CH_W-1:0]   px_index,
   output logic              px_blank_n
);
   genvar k;
   generate
      for (k = 0; k < HOLD_N; k++) begin : g_slot
         logic [WORD_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= '0;
            else if (blank_n && cnt == CNT_W'(k))
               slot_q <= word;
         end
      end
   endgenerate

   logic [WORD_W-1:0] h0, h1;
   assign h0 = g_slot[0].slot_q;
   assign h1 = g_slot[1].slot_q;

   logic [CH_W-1:0] r_c, g_c, b_c, idx_c;
   logic            dir_c;

   always_comb begin
      r_c = '0; g_c = '0; b_c = '0; idx_c = '0; dir_c = 1'b0;
      case (fmt_use)
         FMT_IDX8: idx_c = word[7:0];
         FMT_B555: begin
            r_c = {word[6:2], 3'b000};
            g_c = {word[1:0], h0[7:5], 3'b000};
            b_c = {h0[4:0], 3'b000};
            dir_c = 1'b1;
         end
         FMT_B565: begin
            r_c = {word[7:3], 3'b000};
            g_c = {word[2:0], h0[7:5], 2'b00};
            b_c = {h0[4:0], 3'b000};
            dir_c = 1'b1;
         end
         FMT_B888: begin
            r_c = word[7:0]; g_c = h1[7:0]; b_c = h0[7:0];
            dir_c = 1'b1;
         end
         FMT_W555, FMT_MIX: begin
            if (fmt_use == FMT_W555 || word[15]) begin
               r_c = {word[14:10], 3'b000};
               g_c = {word[9:5], 3'b000};
               b_c = {word[4:0], 3'b000};
               dir_c = 1'b1;
            end else begin
               idx_c = word[7:0];
            end
         end
         FMT_W565: begin
            r_c = {word[15:11], 3'b000};
            g_c = {word[10:5], 2'b00};
            b_c = {word[4:0], 3'b000};
            dir_c = 1'b1;
         end
         FMT_W888: begin
            r_c = word[7:0]; g_c = h0[15:8]; b_c = h0[7:0];
            dir_c = 1'b1;
         end
         FMT_NIB: idx_c = {word[3:0], h0[3:0]};
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         px_valid   <= 1'b0;
         px_direct  <= 1'b0;
         px_rgb     <= '0;
         px_index   <= '0;
         px_blank_n <= 1'b0;
      end else begin
         px_valid   <= last;
         px_blank_n <= blank_n;
         if (last) begin
            px_direct <= dir_c;
            if (dir_c) px_rgb   <= {r_c, g_c, b_c};
            else       px_index <= idx_c;
         end
      end
   end
endmodule

// File: rtl/pixel_word_unpacker.sv
module pixel_word_unpacker
   import pxu_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int CH_W      = 8,
   parameter int CMD_W     = 3,
   parameter int MODE_W    = 8,
   parameter int MAX_WORDS = 3,
   localparam int CNT_W    = $clog2(MAX_WORDS),
   localparam int RGB_W    = 3 * CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] pix_word,
   input  logic              blank_n,
   input  logic              mode_sel,
   input  logic              ext_en,
   input  logic [CMD_W-1:0]  legacy_cmd,
   input  logic [MODE_W-1:0] prim_mode,
   input  logic [MODE_W-1:0] sec_mode,
   output logic              px_valid,
   output logic              px_direct,
   output logic [RGB_W-1:0]  px_rgb,
   output logic [CH_W-1:0]   px_index,
   output logic              px_blank_n
);
   initial begin
      assert (WORD_W == 16) else $error("bus layouts assume a 16-bit word");
      assert (CH_W == 8)    else $error("layouts assume 8-bit channels");
      assert (CMD_W == 3)   else $error("legacy code is 3 bits");
      assert (MODE_W == 8)  else $error("extended code is 8 bits");
      assert (MAX_WORDS >= 3) else $error("three-byte format needs 3 words");
   end

   pxu_fmt_e         fmt_now, fmt_use;
   logic [CNT_W-1:0] cnt;
   logic             last;

   pxu_fmt_decode #(.CMD_W(CMD_W), .MODE_W(MODE_W)) u_dec (
      .ext_en(ext_en), .legacy_cmd(legacy_cmd), .prim_mode(prim_mode),
      .sec_mode(sec_mode), .mode_sel(mode_sel), .fmt(fmt_now)
   );

   pxu_word_seq #(.MAX_WORDS(MAX_WORDS)) u_seq (
      .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .fmt_now(fmt_now),
      .fmt_use(fmt_use), .cnt(cnt), .last(last)
   );

   pxu_assemble #(.WORD_W(WORD_W), .CH_W(CH_W), .MAX_WORDS(MAX_WORDS)) u_asm (
      .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .word(pix_word),
      .cnt(cnt), .fmt_use(fmt_use), .last(last),
      .px_valid(px_valid), .px_direct(px_direct), .px_rgb(px_rgb),
      .px_index(px_index), .px_blank_n(px_blank_n)
   );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       blank_n,
   input logic       ext_en,
   input logic [2:0] legacy_cmd,
   input logic [7:0] prim_mode,
   input logic       mode_sel,
   input logic       px_valid,
   input logic       px_blank_n
);
   // R11: a strobe only follows a captured display word
   a_r11_valid_in_display: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> px_blank_n);

   // R11: delayed display enable
   a_r11_blank_delay: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (px_blank_n == $past(blank_n)));

   // R10: no strobe after a blanking cycle
   a_r10_quiet_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |=> !px_valid);

   // R7: unsupported extended code gives no strobe on its first word
   a_r7_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(blank_n) && ext_en && !mode_sel && prim_mode == 8'h05) |=> !px_valid);

   // R1: first byte of a two-byte 5-6-5 pixel gives no strobe
   a_r1_first_byte_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(blank_n) && !ext_en && legacy_cmd == 3'b110) |=> !px_valid);
endmodule

bind pixel_word_unpacker pxu_checker u_chk (
   .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .ext_en(ext_en),
   .legacy_cmd(legacy_cmd), .prim_mode(prim_mode), .mode_sel(mode_sel),
   .px_valid(px_valid), .px_blank_n(px_blank_n)
);

// File: tb/pixel_word_unpacker_tb.sv
`timescale 1ns/1ps
module pixel_word_unpacker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pix_word = '0;
   logic        blank_n = 1'b0;
   logic        mode_sel = 1'b0;
   logic        ext_en = 1'b0;
   logic [2:0]  legacy_cmd = '0;
   logic [7:0]  prim_mode = '0;
   logic [7:0]  sec_mode = '0;
   logic        px_valid, px_direct, px_blank_n;
   logic [23:0] px_rgb;
   logic [7:0]  px_index;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pixel_word_unpacker u_dut (
      .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .blank_n(blank_n),
      .mode_sel(mode_sel), .ext_en(ext_en), .legacy_cmd(legacy_cmd),
      .prim_mode(prim_mode), .sec_mode(sec_mode), .px_valid(px_valid),
      .px_direct(px_direct), .px_rgb(px_rgb), .px_index(px_index),
      .px_blank_n(px_blank_n)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic        ext;
      logic [2:0]  leg;
      logic [7:0]  pm;
      logic [7:0]  sm;
      logic        ms;
      logic [1:0]  nw;
      logic [15:0] w0;
      logic [15:0] w1;
      logic [15:0] w2;
      logic        ev;
      logic        ed;
      logic [23:0] rgb;
      logic [7:0]  idx;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VT [NV] = '{
      // R1 legacy index, 5-5-5, 5-6-5, 8-8-8
      '{4'd1, 1'b0, 3'b000, 8'h00, 8'h00, 1'b0, 2'd1, 16'hAB5C, 16'h0000, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'h5C},
      '{4'd1, 1'b0, 3'b101, 8'h00, 8'h00, 1'b0, 2'd2, 16'hFFB3, 16'h12E5, 16'h0000, 1'b1, 1'b1, 24'hC86898, 8'h00},
      '{4'd1, 1'b0, 3'b110, 8'h00, 8'h00, 1'b0, 2'd2, 16'h0075, 16'h009E, 16'h0000, 1'b1, 1'b1, 24'h98CCA8, 8'h00},
      '{4'd1, 1'b0, 3'b111, 8'h00, 8'h00, 1'b0, 2'd3, 16'h0011, 16'h0022, 16'h0033, 1'b1, 1'b1, 24'h332211, 8'h00},
      // R2 reserved legacy codes
      '{4'd2, 1'b0, 3'b001, 8'h00, 8'h00, 1'b0, 2'd1, 16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00},
      '{4'd2, 1'b0, 3'b100, 8'h00, 8'h00, 1'b0, 2'd1, 16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00},
      // R3 single-word colour
      '{4'd3, 1'b1, 3'b000, 8'h03, 8'h03, 1'b0, 2'd1, 16'hB33C, 16'h0000, 16'h0000, 1'b1, 1'b1, 24'hB064E0, 8'h00},
      '{4'd3, 1'b1, 3'b000, 8'h02, 8'h02, 1'b0, 2'd1, 16'hD55F, 16'h0000, 16'h0000, 1'b1, 1'b1, 24'hA850F8, 8'h00},
      // R4 two-word 24-bit
      '{4'd4, 1'b1, 3'b000, 8'h04, 8'h04, 1'b0, 2'd2, 16'h5A3C, 16'hFF77, 16'h0000, 1'b1, 1'b1, 24'h775A3C, 8'h00},
      // R5 nibble index
      '{4'd5, 1'b1, 3'b000, 8'h07, 8'h07, 1'b0, 2'd2, 16'hFFF9, 16'hFFF4, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'h49},
      // R6 codes 00h and 01h
      '{4'd6, 1'b1, 3'b000, 8'h00, 8'h00, 1'b0, 2'd1, 16'h12AB, 16'h0000, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'hAB},
      '{4'd6, 1'b1, 3'b000, 8'h01, 8'h01, 1'b0, 2'd1, 16'h7F21, 16'h0000, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'h21},
      '{4'd6, 1'b1, 3'b000, 8'h01, 8'h01, 1'b0, 2'd1, 16'h8421, 16'h0000, 16'h0000, 1'b1, 1'b1, 24'h080808, 8'h00},
      // R7 unsupported extended codes
      '{4'd7, 1'b1, 3'b000, 8'h05, 8'h05, 1'b0, 2'd1, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00},
      '{4'd7, 1'b1, 3'b000, 8'h09, 8'h09, 1'b0, 2'd1, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00},
      '{4'd7, 1'b1, 3'b000, 8'h0A, 8'h0A, 1'b0, 2'd1, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00},
      // R8 primary/secondary choice and legacy immunity
      '{4'd8, 1'b1, 3'b000, 8'h00, 8'h03, 1'b1, 2'd1, 16'hB33C, 16'h0000, 16'h0000, 1'b1, 1'b1, 24'hB064E0, 8'h00},
      '{4'd8, 1'b1, 3'b000, 8'h00, 8'h03, 1'b0, 2'd1, 16'hB33C, 16'h0000, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'h3C},
      '{4'd8, 1'b0, 3'b000, 8'h03, 8'h04, 1'b1, 2'd1, 16'hB33C, 16'h0000, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'h3C}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w, input logic ms);
      blank_n  = 1'b1;
      pix_word = w;
      mode_sel = ms;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      blank_n = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 valid", 32'(px_valid), 32'd0);
      chk("R12 rgb", 32'(px_rgb), 32'd0);
      chk("R12 index", 32'(px_index), 32'd0);
      chk("R12 blank", 32'(px_blank_n), 32'd0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VT[i].req, i);
         ext_en = VT[i].ext; legacy_cmd = VT[i].leg;
         prim_mode = VT[i].pm; sec_mode = VT[i].sm;
         idle(1);
         for (int k = 0; k < int'(VT[i].nw); k++)
            send((k == 0) ? VT[i].w0 : (k == 1) ? VT[i].w1 : VT[i].w2, VT[i].ms);
         chk({tag, " valid"}, 32'(px_valid), 32'(VT[i].ev));
         if (VT[i].ev) begin
            chk({tag, " direct"}, 32'(px_direct), 32'(VT[i].ed));
            if (VT[i].ed) chk({tag, " rgb"}, 32'(px_rgb), 32'(VT[i].rgb));
            else          chk({tag, " index"}, 32'(px_index), 32'(VT[i].idx));
         end
         idle(1);
      end

      // R11 back-to-back 5-6-5 pixels with display held on
      ext_en = 1'b0; legacy_cmd = 3'b110;
      idle(1);
      send(16'h0075, 1'b0);
      chk("R11 no strobe on first byte", 32'(px_valid), 32'd0);
      send(16'h009E, 1'b0);
      chk("R11 strobe A", 32'(px_valid), 32'd1);
      chk("R11 rgb A", 32'(px_rgb), 32'h98CCA8);
      send(16'h00FF, 1'b0);
      chk("R11 strobe one cycle", 32'(px_valid), 32'd0);
      send(16'h0000, 1'b0);
      chk("R11 strobe B", 32'(px_valid), 32'd1);
      chk("R11 rgb B", 32'(px_rgb), 32'h001CF8);
      chk("R11 blank delayed high", 32'(px_blank_n), 32'd1);
      idle(1);
      chk("R11 blank delayed low", 32'(px_blank_n), 32'd0);

      // R10 realignment after a drop in mid-pixel
      legacy_cmd = 3'b111;
      send(16'h00AA, 1'b0);
      send(16'h00BB, 1'b0);
      idle(1);
      chk("R10 partial pixel dropped", 32'(px_valid), 32'd0);
      send(16'h0011, 1'b0);
      send(16'h0022, 1'b0);
      chk("R10 no early strobe", 32'(px_valid), 32'd0);
      send(16'h0033, 1'b0);
      chk("R10 realigned strobe", 32'(px_valid), 32'd1);
      chk("R10 realigned rgb", 32'(px_rgb), 32'h332211);
      pix_word = 16'h0044;
      idle(3);
      chk("R10 quiet while blanking", 32'(px_valid), 32'd0);

      // R9 selector change on the second word is ignored
      ext_en = 1'b1; prim_mode = 8'h04; sec_mode = 8'h03;
      send(16'h5A3C, 1'b0);
      chk("R9 no strobe after word 0", 32'(px_valid), 32'd0);
      send(16'hFF77, 1'b1);
      chk("R9 strobe", 32'(px_valid), 32'd1);
      chk("R9 primary layout kept", 32'(px_rgb), 32'h775A3C);
      idle(2);

      finish_run();
   end
endmodule